// File: doc/BRIEF.md
# Sleep and Wake-Up Sequencer

This block handles the power-down phase of a small 8-bit controller core. When the instruction decoder signals that a sleep instruction is executing, the sequencer stops the oscillator, stalls the core and records in two status flags that a sleep happened. It then waits for a wake source. Wake sources are an interrupt source whose enable and flag bits are both set, a watchdog timeout, or the external reset input. When one arrives, the sequencer restarts the clock, clears the watchdog and releases the core. It also tells the core whether to continue in line or to branch to the interrupt vector after the prefetched instruction.

A sleep request that races an interrupt is resolved by timing. If an enabled flag was already pending in the cycle before the request, the sleep does nothing. If the flag appears in the same cycle as the request or later, the sleep takes full effect and the device wakes at once. The global interrupt enable never prevents a wake-up. It only selects the resume action.

All logic runs on one clock. Power-on reset is asynchronous and active low. The external reset input is sampled synchronously. The oscillator enable is combinational while asleep, so it rises in the same cycle that a wake condition appears.

Top module: `slumber_ctrl`

## Requirements
- R1: During or after power-on reset: `awake_flag`=1, `no_wdt_flag`=1, `osc_en`=1, `core_stall`=0, `wdt_clr`=0, `resume_valid`=0, `resume_branch`=0. This holds even if the reset arrives while asleep.
- R2: A `sleep_req` while awake enters sleep when no enabled source was pending in the previous cycle and no watchdog timeout occurs in the same cycle. On the next cycle `awake_flag`=0, `no_wdt_flag`=1, `wdt_clr`=1 for one cycle, `core_stall`=1, and `osc_en`=0 while no wake condition is present.
- R3: If any source had both `irq_en[i]` and `irq_flag[i]` set in the cycle before `sleep_req`, the request is a no-op: no stall, no `wdt_clr`, and both status flags keep their values.
- R4: While asleep, a source with both its enable and flag bits set raises `osc_en` in the same cycle, whatever `gie` is. `core_stall` falls on the next cycle, and `resume_valid` is high for exactly that one cycle.
- R5: `resume_branch` (1 = branch to the vector after the next instruction, 0 = continue in line) equals `gie` when an enabled interrupt was present in the wake cycle. Otherwise it is 0. It is 0 whenever `resume_valid` is 0.
- R6: A watchdog wake (`wdt_timeout` high while asleep) clears `no_wdt_flag`, leaves `awake_flag` at 0 and produces a `resume_valid` pulse.
- R7: Every wake-up, whatever its source, gives a one-cycle `wdt_clr` in the cycle after the wake condition.
- R8: An enabled flag that appears in the same cycle as `sleep_req` still lets the sleep take full effect (`awake_flag`=0, `no_wdt_flag`=1). The device then wakes in the following cycle.
- R9: `ext_rst_n`=0 while asleep returns the block to awake on the next cycle with no `resume_valid` and unchanged status flags. `ext_rst_n`=0 while awake has no visible effect.
- R10: `clrwdt_req` while awake, with no `sleep_req` or `wdt_timeout` in that cycle, sets both status flags and pulses `wdt_clr` on the next cycle.
- R11: `wdt_timeout` while awake (a watchdog reset) sets `awake_flag`=1 and `no_wdt_flag`=0 on the next cycle, without `wdt_clr`, stall or resume.
- R12: A flag bit whose enable bit is 0 neither wakes the device nor raises `osc_en`.
- R13: `sleep_req` and `clrwdt_req` are ignored while asleep: no `wdt_clr`, and the status flags and stall are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sleep_req | input | 1 | One-cycle strobe: sleep instruction executing |
| clrwdt_req | input | 1 | One-cycle strobe: clear-watchdog instruction executing |
| gie | input | 1 | Global interrupt enable |
| irq_en | input | NSRC | Per-source interrupt enable bits |
| irq_flag | input | NSRC | Per-source interrupt flag bits |
| wdt_timeout | input | 1 | Watchdog timeout strobe |
| ext_rst_n | input | 1 | External reset input, active low, synchronous |
| osc_en | output | 1 | Oscillator driver enable |
| core_stall | output | 1 | Holds the core while asleep |
| wdt_clr | output | 1 | One-cycle watchdog clear pulse |
| awake_flag | output | 1 | Power-down status: 1 after power-up, 0 after a sleep |
| no_wdt_flag | output | 1 | Timeout status: 0 after a watchdog timeout |
| resume_valid | output | 1 | One-cycle pulse: core resumes after wake-up |
| resume_branch | output | 1 | With resume_valid: 1 = branch to vector after next instruction |

## Verification
The hardest situation to reach is the race between a sleep request and an interrupt flag. Whether the sleep is a no-op or a full sleep followed by an immediate wake depends on whether the flag rose one cycle before the strobe or in the same cycle. The vector table fixes both timings exactly: one row holds the flag high for a cycle before the strobe row, and another raises flag and strobe in the same row. The status flags, `wdt_clr` and the stall are then compared on the next rows. A second case that is hard to reach is a wake where the watchdog timeout and an interrupt coincide with `gie` set. A directed test covers it and checks that the timeout flag and the branch decision are both applied.

// File: rtl/slumber_pkg.sv
package slumber_pkg;

  typedef enum logic [1:0] {
    PH_AWAKE  = 2'd0,
    PH_ASLEEP = 2'd1,
    PH_WAKING = 2'd2
  } phase_e;

  typedef struct packed {
    logic clr_awake;
    logic set_awake;
    logic clr_nwd;
    logic set_nwd;
  } stat_cmd_t;

endpackage

// File: rtl/slumber_wake_detect.sv
module slumber_wake_detect #(
  parameter int NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_en,
  input  logic [NSRC-1:0] irq_flag,
  output logic            pend_now,
  output logic            pend_prev
);

  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = irq_en[g] & irq_flag[g];
  end

  assign pend_now = |hit;

  // one-cycle history separates "pending before" from "arriving with" a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_prev <= 1'b0;
    else        pend_prev <= pend_now;
  end

endmodule

// File: rtl/slumber_status.sv
module slumber_status
  import slumber_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  stat_cmd_t cmd,
  output logic      awake_flag,
  output logic      no_wdt_flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      awake_flag  <= 1'b1;
      no_wdt_flag <= 1'b1;
    end else begin
      if (cmd.clr_awake)      awake_flag <= 1'b0;
      else if (cmd.set_awake) awake_flag <= 1'b1;
      if (cmd.clr_nwd)        no_wdt_flag <= 1'b0;
      else if (cmd.set_nwd)   no_wdt_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/slumber_fsm.sv
module slumber_fsm
  import slumber_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      clrwdt_req,
  input  logic      gie,
  input  logic      wdt_timeout,
  input  logic      ext_rst_n,
  input  logic      pend_now,
  input  logic      pend_prev,
  output stat_cmd_t cmd,
  output logic      osc_en,
  output logic      core_stall,
  output logic      wdt_clr,
  output logic      resume_valid,
  output logic      resume_branch
);

  phase_e phase_q, phase_d;
  logic   awake, asleep;
  logic   enter, nop_sleep, clr_cmd, wdt_rst;
  logic   xrst_hit, wake_any, wake_run;
  logic   wclr_d, rv_d, rb_d;

  assign awake  = (phase_q == PH_AWAKE);
  assign asleep = (phase_q == PH_ASLEEP);

  always_comb begin
    wdt_rst   = awake & wdt_timeout;
    enter     = awake & sleep_req & ~pend_prev & ~wdt_timeout;
    nop_sleep = awake & sleep_req & pend_prev;
    clr_cmd   = awake & clrwdt_req & ~sleep_req & ~wdt_timeout;
    xrst_hit  = asleep & ~ext_rst_n;
    wake_any  = asleep & (pend_now | wdt_timeout | ~ext_rst_n);
    wake_run  = wake_any & ext_rst_n;
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_AWAKE:  if (enter) phase_d = PH_ASLEEP;
      PH_ASLEEP: begin
        if (xrst_hit)      phase_d = PH_AWAKE;
        else if (wake_any) phase_d = PH_WAKING;
      end
      PH_WAKING: phase_d = PH_AWAKE;
      default:   phase_d = PH_AWAKE;
    endcase
  end

  always_comb begin
    cmd           = '0;
    cmd.clr_awake = enter;
    cmd.set_awake = (clr_cmd | wdt_rst) & ~nop_sleep;
    cmd.set_nwd   = enter | clr_cmd;
    cmd.clr_nwd   = wdt_rst | (wake_run & wdt_timeout);
  end

  always_comb begin
    wclr_d = enter | clr_cmd | wake_any;
    rv_d   = wake_run;
    rb_d   = wake_run & pend_now & gie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q       <= PH_AWAKE;
      wdt_clr       <= 1'b0;
      resume_valid  <= 1'b0;
      resume_branch <= 1'b0;
    end else begin
      phase_q       <= phase_d;
      wdt_clr       <= wclr_d;
      resume_valid  <= rv_d;
      resume_branch <= rb_d;
    end
  end

  // clock restarts in the very cycle a wake condition shows up
  assign osc_en     = ~asleep | wake_any;
  assign core_stall = asleep;

endmodule

// File: rtl/slumber_ctrl.sv
module slumber_ctrl
  import slumber_pkg::*;
#(
  parameter int NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_req,
  input  logic            clrwdt_req,
  input  logic            gie,
  input  logic [NSRC-1:0] irq_en,
  input  logic [NSRC-1:0] irq_flag,
  input  logic            wdt_timeout,
  input  logic            ext_rst_n,
  output logic            osc_en,
  output logic            core_stall,
  output logic            wdt_clr,
  output logic            awake_flag,
  output logic            no_wdt_flag,
  output logic            resume_valid,
  output logic            resume_branch
);

  logic      pend_now, pend_prev;
  stat_cmd_t cmd;

  slumber_wake_detect #(.NSRC(NSRC)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_en    (irq_en),
    .irq_flag  (irq_flag),
    .pend_now  (pend_now),
    .pend_prev (pend_prev)
  );

  slumber_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_req     (sleep_req),
    .clrwdt_req    (clrwdt_req),
    .gie           (gie),
    .wdt_timeout   (wdt_timeout),
    .ext_rst_n     (ext_rst_n),
    .pend_now      (pend_now),
    .pend_prev     (pend_prev),
    .cmd           (cmd),
    .osc_en        (osc_en),
    .core_stall    (core_stall),
    .wdt_clr       (wdt_clr),
    .resume_valid  (resume_valid),
    .resume_branch (resume_branch)
  );

  slumber_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .awake_flag  (awake_flag),
    .no_wdt_flag (no_wdt_flag)
  );

endmodule

// File: rtl/slumber_ctrl_chk.sv
module slumber_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_req,
  input logic clrwdt_req,
  input logic wdt_timeout,
  input logic ext_rst_n,
  input logic pend_prev,
  input logic osc_en,
  input logic core_stall,
  input logic wdt_clr,
  input logic awake_flag,
  input logic no_wdt_flag,
  input logic resume_valid,
  input logic resume_branch
);

  logic running;
  assign running = ~core_stall & ~resume_valid;

  assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sleep_req && !pend_prev && !wdt_timeout)
      |=> (!awake_flag && no_wdt_flag && wdt_clr && core_stall));

  assert_nop_sleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sleep_req && pend_prev && !wdt_timeout)
      |=> ($stable(awake_flag) && $stable(no_wdt_flag) && !core_stall && !wdt_clr));

  assert_wake_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall && osc_en && ext_rst_n) |=> (!core_stall && resume_valid));

  assert_no_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall && !osc_en) |=> core_stall);

  assert_resume_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid |=> !resume_valid);

  assert_branch_qual_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resume_branch |-> resume_valid);

  assert_wdt_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall && wdt_timeout && ext_rst_n) |=> (!no_wdt_flag && !awake_flag));

  assert_wake_clears_wdt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall && osc_en) |=> wdt_clr);

  assert_ext_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall && !ext_rst_n)
      |=> (!core_stall && !resume_valid && $stable(awake_flag) && $stable(no_wdt_flag)));

  assert_clrwdt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && clrwdt_req && !sleep_req && !wdt_timeout)
      |=> (awake_flag && no_wdt_flag && wdt_clr));

  assert_wdt_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wdt_timeout) |=> (awake_flag && !no_wdt_flag && !core_stall));

endmodule

bind slumber_ctrl slumber_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sleep_req     (sleep_req),
  .clrwdt_req    (clrwdt_req),
  .wdt_timeout   (wdt_timeout),
  .ext_rst_n     (ext_rst_n),
  .pend_prev     (pend_prev),
  .osc_en        (osc_en),
  .core_stall    (core_stall),
  .wdt_clr       (wdt_clr),
  .awake_flag    (awake_flag),
  .no_wdt_flag   (no_wdt_flag),
  .resume_valid  (resume_valid),
  .resume_branch (resume_branch)
);

// File: tb/slumber_ctrl_test.sv
`timescale 1ns/1ps
module slumber_ctrl_test;

  localparam int NSRC = 6;
  localparam int NVEC = 38;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, clrwdt_req = 1'b0, gie = 1'b0;
  logic wdt_timeout = 1'b0, ext_rst_n = 1'b1;
  logic [NSRC-1:0] irq_en = '0, irq_flag = '0;
  logic osc_en, core_stall, wdt_clr, awake_flag, no_wdt_flag;
  logic resume_valid, resume_branch;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  slumber_ctrl #(.NSRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .clrwdt_req(clrwdt_req),
    .gie(gie), .irq_en(irq_en), .irq_flag(irq_flag), .wdt_timeout(wdt_timeout),
    .ext_rst_n(ext_rst_n), .osc_en(osc_en), .core_stall(core_stall),
    .wdt_clr(wdt_clr), .awake_flag(awake_flag), .no_wdt_flag(no_wdt_flag),
    .resume_valid(resume_valid), .resume_branch(resume_branch)
  );

  // {sleep,clrwdt,gie,wdt,ext_rst_n} {en} {flag}
  // expected {osc,stall,awake,no_wdt,wclr,rv,rb} {tag}
  localparam logic [27:0] VECS [NVEC] = '{
    {5'b00001, 6'h00, 6'h00, 7'b1011000, 4'd1 },  // R1 idle
    {5'b10001, 6'h01, 6'h00, 7'b1011000, 4'd2 },  // R2 strobe cycle
    {5'b00001, 6'h01, 6'h00, 7'b0101100, 4'd2 },  // R2 asleep
    {5'b00001, 6'h01, 6'h02, 7'b0101000, 4'd12},  // R12 masked flag
    {5'b00001, 6'h01, 6'h01, 7'b1101000, 4'd4 },  // R4 wake seen, gie=0
    {5'b00001, 6'h01, 6'h00, 7'b1001110, 4'd5 },  // R5 in-line resume
    {5'b00001, 6'h00, 6'h00, 7'b1001000, 4'd4 },  // R4 single pulse
    {5'b10101, 6'h20, 6'h00, 7'b1001000, 4'd2 },  // R2 sleep, gie=1
    {5'b00101, 6'h20, 6'h00, 7'b0101100, 4'd2 },
    {5'b00101, 6'h20, 6'h20, 7'b1101000, 4'd5 },
    {5'b00101, 6'h20, 6'h00, 7'b1001111, 4'd5 },  // R5 branch
    {5'b00001, 6'h00, 6'h00, 7'b1001000, 4'd5 },
    {5'b01001, 6'h00, 6'h00, 7'b1001000, 4'd10},  // R10 clrwdt
    {5'b00001, 6'h04, 6'h04, 7'b1011100, 4'd10},
    {5'b10001, 6'h04, 6'h04, 7'b1011000, 4'd3 },  // R3 pending before strobe
    {5'b00001, 6'h04, 6'h04, 7'b1011000, 4'd3 },
    {5'b00001, 6'h00, 6'h00, 7'b1011000, 4'd3 },
    {5'b10001, 6'h08, 6'h08, 7'b1011000, 4'd8 },  // R8 flag with strobe
    {5'b00001, 6'h08, 6'h08, 7'b1101100, 4'd8 },
    {5'b00001, 6'h08, 6'h00, 7'b1001110, 4'd7 },  // R7 clear on wake
    {5'b00001, 6'h00, 6'h00, 7'b1001000, 4'd8 },
    {5'b10001, 6'h00, 6'h00, 7'b1001000, 4'd2 },
    {5'b00001, 6'h00, 6'h00, 7'b0101100, 4'd6 },
    {5'b00011, 6'h00, 6'h00, 7'b1101000, 4'd6 },  // R6 watchdog wake
    {5'b00001, 6'h00, 6'h00, 7'b1000110, 4'd6 },
    {5'b00001, 6'h00, 6'h00, 7'b1000000, 4'd6 },
    {5'b10001, 6'h00, 6'h00, 7'b1000000, 4'd13},
    {5'b00001, 6'h00, 6'h00, 7'b0101100, 4'd13},
    {5'b01001, 6'h00, 6'h00, 7'b0101000, 4'd13},  // R13 clrwdt asleep
    {5'b10001, 6'h00, 6'h00, 7'b0101000, 4'd13},  // R13 sleep asleep
    {5'b00001, 6'h00, 6'h00, 7'b0101000, 4'd13},
    {5'b00000, 6'h00, 6'h00, 7'b1101000, 4'd9 },  // R9 ext reset asleep
    {5'b00001, 6'h00, 6'h00, 7'b1001100, 4'd9 },
    {5'b00001, 6'h00, 6'h00, 7'b1001000, 4'd9 },
    {5'b00011, 6'h00, 6'h00, 7'b1001000, 4'd11},  // R11 watchdog reset
    {5'b00001, 6'h00, 6'h00, 7'b1010000, 4'd11},
    {5'b01001, 6'h00, 6'h00, 7'b1010000, 4'd10},
    {5'b00001, 6'h00, 6'h00, 7'b1011100, 4'd10}
  };

  function automatic logic [6:0] observe();
    return {osc_en, core_stall, awake_flag, no_wdt_flag, wdt_clr, resume_valid, resume_branch};
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    logic [6:0] got;
    got = observe();
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    sleep_req = 1'b0; clrwdt_req = 1'b0; gie = 1'b0;
    wdt_timeout = 1'b0; ext_rst_n = 1'b1; irq_en = '0; irq_flag = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired got hang expected completion");
    finish_run();
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R1 in reset", 7'b1011000);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      string tag;
      v = VECS[i];
      @(negedge clk);
      sleep_req   = v[27];
      clrwdt_req  = v[26];
      gie         = v[25];
      wdt_timeout = v[24];
      ext_rst_n   = v[23];
      irq_en      = v[22:17];
      irq_flag    = v[16:11];
      #1.5;
      tag = $sformatf("R%0d vector %0d", v[3:0], i);
      check(tag, v[10:4]);
    end

    // R9: external reset while awake is invisible
    @(negedge clk); idle_inputs(); ext_rst_n = 1'b0;
    #1.5 check("R9 ext reset awake", 7'b1011000);
    @(negedge clk); ext_rst_n = 1'b1;
    #1.5 check("R9 ext reset awake after", 7'b1011000);

    // R6 with R5: watchdog and interrupt together, gie set
    @(negedge clk); sleep_req = 1'b1; gie = 1'b1; irq_en = 6'h01;
    @(negedge clk); sleep_req = 1'b0;
    #1.5 check("R2 asleep before joint wake", 7'b0101100);
    @(negedge clk); irq_flag = 6'h01; wdt_timeout = 1'b1;
    #1.5 check("R4 joint wake seen", 7'b1101000);
    @(negedge clk); irq_flag = '0; wdt_timeout = 1'b0;
    #1.5 check("R6 joint wake timeout flag and branch", 7'b1000111);
    @(negedge clk); idle_inputs();
    #1.5 check("R6 joint wake settled", 7'b1000000);

    // R1: power-on reset arriving during sleep
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    #1.5 check("R2 asleep before reset", 7'b0101100);
    #0.2 rst_n = 1'b0;
    #0.2 check("R1 reset while asleep", 7'b1011000);
    @(negedge clk); rst_n = 1'b1;
    #1.5 check("R1 after reset release", 7'b1011000);

    finish_run();
  end

endmodule